// File: doc/BRIEF.md
# Dataflow Task Sequencer With Queue Counters

This block runs one abstract program for a single processing element. Each instruction is a token-level step rather than a datapath operation. A compute step burns a stated number of cycles. A send step hands a transfer command to a communication port. A receive step waits until a logical queue holds enough data and then consumes it. A loop step repeats a stretch of the program a set number of times. The program sits in a small local store, and a program counter walks through it.

Sixteen logical queues each hold a 16-bit fill level. No data values are kept, only amounts. A separate arrival input credits a queue when remote data lands, and that credit can free a receive that is waiting on the queue. The busy, stall and halted outputs, together with the program counter, let a timeline recorder see what the sequencer is doing in every cycle. A monitor select brings out the level of any one queue.

Software loads the program one word at a time and pulses start. The sequencer then runs until the program counter passes the last loaded word.

Top module: `fts_sequencer`

## Requirements
- R1: After reset, busy, halted, stall and snd_valid are 0, pc is 0 and every queue level reads 0.
- R2: An instruction word is {op[25:24], qa[23:20], qb[19:16], amt[15:0]}. Op 00 is compute. It keeps pc unchanged for max(amt,1) cycles and then advances pc by one.
- R3: Op 01 is send. While it is the current instruction, snd_valid is 1 with snd_src=qa, snd_dst=qb and snd_amt=amt. pc and the command stay unchanged, and stall is 1, until a cycle with snd_ready=1. In that cycle the command is accepted and pc advances.
- R4: An accepted send subtracts amt from queue qa. The result is floored at 0. A send that is waiting does not change the queue.
- R5: Op 10 is receive. If queue qa holds at least amt, the sequencer subtracts amt and advances in one cycle. Otherwise stall is 1 and pc holds until arrivals bring the level up to amt.
- R6: An arrival (arr_valid with arr_queue and arr_amt) adds arr_amt to that queue in the next cycle. The sum saturates at 65535.
- R7: An arrival and a receive or send debit on the same queue in the same cycle are both applied. The level becomes old + arrival − debit.
- R8: Op 11 is loop, with target address in qa and repeat count in amt. The first time it is reached it jumps to the target amt times in a row. It then falls through. A count of 0 falls through at once. Each new run reloads the count.
- R9: The program end is the address of the most recent load plus one. When pc reaches it, the next cycle gives halted=1 and busy=0, and halted stays set until start. Start from idle or halt begins again at pc 0.
- R10: Start is ignored while busy. pc is not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Write load_word into the program store |
| load_addr | input | ADDR_W | Program store address; also sets the program end |
| load_word | input | 26 | Instruction word |
| start | input | 1 | Begin running at address 0 |
| arr_valid | input | 1 | Remote data arrival |
| arr_queue | input | 4 | Queue credited by the arrival |
| arr_amt | input | 16 | Amount arrived |
| snd_valid | output | 1 | Send command offered |
| snd_ready | input | 1 | Communication port accepts the command |
| snd_src | output | 4 | Local source queue |
| snd_dst | output | 4 | Remote destination queue |
| snd_amt | output | 16 | Amount to transfer |
| mon_queue | input | 4 | Queue selected for observation |
| mon_level | output | 16 | Fill level of the selected queue |
| pc | output | PC_W | Program counter |
| busy | output | 1 | Program running (includes stalled cycles) |
| stall | output | 1 | Current instruction is blocked this cycle |
| halted | output | 1 | Program ran past its end |

## Verification
Two things can land on the same queue counter in one cycle: the arrival credit, and the debit from an executing receive or accepted send. The bench sets a queue to 3 and starts a program whose first word is a receive of 3. It then drives an arrival of 10 to that queue during exactly the cycle in which the receive executes. It expects a level of 10 and pc at 1, where a lost event would leave 0 or 13. The release of a stalled receive is also checked: an arrival becomes visible one cycle before the receive consumes it.

// File: rtl/fts_pkg.sv
package fts_pkg;
  localparam int OP_W    = 2;
  localparam int QID_W   = 4;
  localparam int AMT_W   = 16;
  localparam int NUM_Q   = 1 << QID_W;
  localparam int INSTR_W = OP_W + 2 * QID_W + AMT_W;

  typedef enum logic [OP_W-1:0] {
    OP_COMPUTE = 2'b00,
    OP_SEND    = 2'b01,
    OP_RECV    = 2'b10,
    OP_LOOP    = 2'b11
  } op_e;

  typedef struct packed {
    op_e              op;
    logic [QID_W-1:0] qa;
    logic [QID_W-1:0] qb;
    logic [AMT_W-1:0] amt;
  } instr_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HALT = 2'd2
  } seq_state_e;
endpackage

// File: rtl/fts_rst_sync.sv
module fts_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/fts_prog_mem.sv
module fts_prog_mem
  import fts_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 4,
  parameter int PC_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [INSTR_W-1:0] wr_data,
  input  logic [PC_W-1:0]    rd_pc,
  output instr_t             rd_instr,
  output logic [PC_W-1:0]    prog_len
);
  logic [INSTR_W-1:0] store_q [DEPTH];
  logic [PC_W-1:0]    len_q;
  logic [PC_W-1:0]    len_d;
  logic               addr_ok;
  logic [ADDR_W-1:0]  rd_idx;

  assign addr_ok = (PC_W'(wr_addr) < PC_W'(DEPTH));

  always_comb begin
    len_d = len_q;
    if (wr_en && addr_ok) len_d = PC_W'(wr_addr) + PC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) len_q <= '0;
    else        len_q <= len_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en && addr_ok) store_q[wr_addr] <= wr_data;
  end

  always_comb begin
    rd_idx = '0;
    if (rd_pc < PC_W'(DEPTH)) rd_idx = rd_pc[ADDR_W-1:0];
  end

  assign rd_instr = instr_t'(store_q[rd_idx]);
  assign prog_len = len_q;
endmodule

// File: rtl/fts_queue_bank.sv
module fts_queue_bank
  import fts_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cr_valid,
  input  logic [QID_W-1:0] cr_q,
  input  logic [AMT_W-1:0] cr_amt,
  input  logic             db_valid,
  input  logic [QID_W-1:0] db_q,
  input  logic [AMT_W-1:0] db_amt,
  input  logic [QID_W-1:0] sel_a,
  output logic [AMT_W-1:0] lvl_a,
  input  logic [QID_W-1:0] sel_m,
  output logic [AMT_W-1:0] lvl_m
);
  localparam int SUM_W = AMT_W + 1;
  localparam logic [SUM_W-1:0] SAT_MAX = SUM_W'({AMT_W{1'b1}});

  logic [AMT_W-1:0] level [NUM_Q];

  for (genvar g = 0; g < NUM_Q; g++) begin : g_queue
    logic             hit_cr;
    logic             hit_db;
    logic [SUM_W-1:0] added;
    logic [SUM_W-1:0] remain;
    logic [AMT_W-1:0] cnt_d;
    logic [AMT_W-1:0] cnt_q;
    logic             cnt_en;

    always_comb begin
      hit_cr = cr_valid && (cr_q == QID_W'(g));
      hit_db = db_valid && (db_q == QID_W'(g));
      added  = {1'b0, cnt_q} + (hit_cr ? {1'b0, cr_amt} : '0);
      remain = added;
      if (hit_db) begin
        if (added >= {1'b0, db_amt}) remain = added - {1'b0, db_amt};
        else                         remain = '0;
      end
      cnt_d  = (remain > SAT_MAX) ? {AMT_W{1'b1}} : remain[AMT_W-1:0];
      cnt_en = hit_cr || hit_db;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (cnt_en) cnt_q <= cnt_d;
    end

    assign level[g] = cnt_q;
  end

  assign lvl_a = level[sel_a];
  assign lvl_m = level[sel_m];
endmodule

// File: rtl/fts_ctrl.sv
module fts_ctrl
  import fts_pkg::*;
#(
  parameter int PC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  instr_t           instr,
  input  logic [PC_W-1:0]  prog_len,
  input  logic             snd_ready,
  input  logic [AMT_W-1:0] lvl_a,
  output logic [QID_W-1:0] lvl_sel,
  output logic             db_valid,
  output logic [QID_W-1:0] db_q,
  output logic [AMT_W-1:0] db_amt,
  output logic             snd_valid,
  output logic [QID_W-1:0] snd_src,
  output logic [QID_W-1:0] snd_dst,
  output logic [AMT_W-1:0] snd_amt,
  output logic [PC_W-1:0]  pc,
  output logic             busy,
  output logic             stall,
  output logic             halted
);
  seq_state_e       state_q, state_d;
  logic [PC_W-1:0]  pc_q, pc_d;
  logic [AMT_W-1:0] cyc_q, cyc_d;
  logic             lp_act_q, lp_act_d;
  logic [AMT_W-1:0] lp_cnt_q, lp_cnt_d;
  logic             in_prog;
  logic             blocked;
  logic [AMT_W:0]   cyc_inc;
  logic [PC_W-1:0]  pc_inc;
  logic [PC_W-1:0]  lp_target;

  assign in_prog   = (pc_q < prog_len);
  assign cyc_inc   = {1'b0, cyc_q} + (AMT_W + 1)'(1);
  assign pc_inc    = pc_q + PC_W'(1);
  assign lp_target = PC_W'(instr.qa);

  always_comb begin
    state_d   = state_q;
    pc_d      = pc_q;
    cyc_d     = cyc_q;
    lp_act_d  = lp_act_q;
    lp_cnt_d  = lp_cnt_q;
    blocked   = 1'b0;
    snd_valid = 1'b0;
    db_valid  = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (!in_prog) begin
          state_d = ST_HALT;
        end else begin
          unique case (instr.op)
            OP_COMPUTE: begin
              if (cyc_inc >= {1'b0, instr.amt}) begin
                cyc_d = '0;
                pc_d  = pc_inc;
              end else begin
                cyc_d = cyc_inc[AMT_W-1:0];
              end
            end
            OP_SEND: begin
              snd_valid = 1'b1;
              if (snd_ready) begin
                db_valid = 1'b1;
                pc_d     = pc_inc;
              end else begin
                blocked = 1'b1;
              end
            end
            OP_RECV: begin
              if (lvl_a >= instr.amt) begin
                db_valid = 1'b1;
                pc_d     = pc_inc;
              end else begin
                blocked = 1'b1;
              end
            end
            OP_LOOP: begin
              if (!lp_act_q) begin
                if (instr.amt == '0) begin
                  pc_d = pc_inc;
                end else begin
                  lp_act_d = 1'b1;
                  lp_cnt_d = instr.amt - AMT_W'(1);
                  pc_d     = lp_target;
                end
              end else if (lp_cnt_q == '0) begin
                lp_act_d = 1'b0;
                pc_d     = pc_inc;
              end else begin
                lp_cnt_d = lp_cnt_q - AMT_W'(1);
                pc_d     = lp_target;
              end
            end
            default: ;
          endcase
        end
      end
      default: begin
        if (start) begin
          state_d  = ST_RUN;
          pc_d     = '0;
          cyc_d    = '0;
          lp_act_d = 1'b0;
          lp_cnt_d = '0;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      pc_q     <= '0;
      cyc_q    <= '0;
      lp_act_q <= 1'b0;
      lp_cnt_q <= '0;
    end else begin
      state_q  <= state_d;
      pc_q     <= pc_d;
      cyc_q    <= cyc_d;
      lp_act_q <= lp_act_d;
      lp_cnt_q <= lp_cnt_d;
    end
  end

  assign lvl_sel = instr.qa;
  assign db_q    = instr.qa;
  assign db_amt  = instr.amt;
  assign snd_src = instr.qa;
  assign snd_dst = instr.qb;
  assign snd_amt = instr.amt;
  assign pc      = pc_q;
  assign busy    = (state_q == ST_RUN);
  assign halted  = (state_q == ST_HALT);
  assign stall   = blocked;
endmodule

// File: rtl/fts_sequencer.sv
module fts_sequencer
  import fts_pkg::*;
#(
  parameter  int PROG_DEPTH = 16,
  localparam int ADDR_W     = (PROG_DEPTH > 1) ? $clog2(PROG_DEPTH) : 1,
  localparam int PC_W       = $clog2(PROG_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_en,
  input  logic [ADDR_W-1:0]  load_addr,
  input  logic [INSTR_W-1:0] load_word,
  input  logic               start,
  input  logic               arr_valid,
  input  logic [QID_W-1:0]   arr_queue,
  input  logic [AMT_W-1:0]   arr_amt,
  output logic               snd_valid,
  input  logic               snd_ready,
  output logic [QID_W-1:0]   snd_src,
  output logic [QID_W-1:0]   snd_dst,
  output logic [AMT_W-1:0]   snd_amt,
  input  logic [QID_W-1:0]   mon_queue,
  output logic [AMT_W-1:0]   mon_level,
  output logic [PC_W-1:0]    pc,
  output logic               busy,
  output logic               stall,
  output logic               halted
);
  logic             rst_n_s;
  instr_t           cur_instr;
  logic [PC_W-1:0]  prog_len;
  logic [QID_W-1:0] lvl_sel;
  logic [AMT_W-1:0] lvl_a;
  logic             db_valid;
  logic [QID_W-1:0] db_q;
  logic [AMT_W-1:0] db_amt;

  fts_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  fts_prog_mem #(
    .DEPTH  (PROG_DEPTH),
    .ADDR_W (ADDR_W),
    .PC_W   (PC_W)
  ) u_mem (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .wr_en    (load_en),
    .wr_addr  (load_addr),
    .wr_data  (load_word),
    .rd_pc    (pc),
    .rd_instr (cur_instr),
    .prog_len (prog_len)
  );

  fts_queue_bank u_queues (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .cr_valid (arr_valid),
    .cr_q     (arr_queue),
    .cr_amt   (arr_amt),
    .db_valid (db_valid),
    .db_q     (db_q),
    .db_amt   (db_amt),
    .sel_a    (lvl_sel),
    .lvl_a    (lvl_a),
    .sel_m    (mon_queue),
    .lvl_m    (mon_level)
  );

  fts_ctrl #(
    .PC_W (PC_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .start     (start),
    .instr     (cur_instr),
    .prog_len  (prog_len),
    .snd_ready (snd_ready),
    .lvl_a     (lvl_a),
    .lvl_sel   (lvl_sel),
    .db_valid  (db_valid),
    .db_q      (db_q),
    .db_amt    (db_amt),
    .snd_valid (snd_valid),
    .snd_src   (snd_src),
    .snd_dst   (snd_dst),
    .snd_amt   (snd_amt),
    .pc        (pc),
    .busy      (busy),
    .stall     (stall),
    .halted    (halted)
  );
endmodule

// File: rtl/fts_sequencer_chk.sv
module fts_sequencer_chk #(
  parameter int PC_W = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            snd_valid,
  input logic            snd_ready,
  input logic [3:0]      snd_src,
  input logic [3:0]      snd_dst,
  input logic [15:0]     snd_amt,
  input logic [PC_W-1:0] pc,
  input logic            busy,
  input logic            stall,
  input logic            halted
);
  // R3: an unaccepted command is held unchanged
  a_r3_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
    snd_valid && !snd_ready |=> snd_valid && $stable(snd_src) && $stable(snd_dst)
                                && $stable(snd_amt) && $stable(pc));

  // R3: a command is only offered while running
  a_r3_cmd_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    snd_valid |-> busy);

  // R5: a blocked instruction does not move the program counter
  a_r5_stall_holds_pc: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(pc));

  // R9: halted and busy never together
  a_r9_halt_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && halted));

  // R9: halt persists until start
  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted && !start |=> halted);
endmodule

bind fts_sequencer fts_sequencer_chk #(.PC_W(PC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .snd_valid (snd_valid),
  .snd_ready (snd_ready),
  .snd_src   (snd_src),
  .snd_dst   (snd_dst),
  .snd_amt   (snd_amt),
  .pc        (pc),
  .busy      (busy),
  .stall     (stall),
  .halted    (halted)
);

// File: tb/fts_sequencer_bench.sv
module fts_sequencer_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        load_en;
  logic [3:0]  load_addr;
  logic [25:0] load_word;
  logic        start;
  logic        arr_valid;
  logic [3:0]  arr_queue;
  logic [15:0] arr_amt;
  logic        snd_valid;
  logic        snd_ready;
  logic [3:0]  snd_src;
  logic [3:0]  snd_dst;
  logic [15:0] snd_amt;
  logic [3:0]  mon_queue;
  logic [15:0] mon_level;
  logic [4:0]  pc;
  logic        busy;
  logic        stall;
  logic        halted;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  fts_sequencer u_fts_sequencer (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
    .load_word(load_word), .start(start), .arr_valid(arr_valid),
    .arr_queue(arr_queue), .arr_amt(arr_amt), .snd_valid(snd_valid),
    .snd_ready(snd_ready), .snd_src(snd_src), .snd_dst(snd_dst),
    .snd_amt(snd_amt), .mon_queue(mon_queue), .mon_level(mon_level),
    .pc(pc), .busy(busy), .stall(stall), .halted(halted)
  );

  // compute delays and the busy-cycle count each must give: max(D,1) + 1
  localparam int NROW = 6;
  localparam int DLY_TAB [NROW][2] = '{
    '{0, 2}, '{1, 2}, '{2, 3}, '{5, 6}, '{17, 18}, '{40, 41}
  };

  function automatic logic [25:0] mk(input logic [1:0] op, input logic [3:0] qa,
                                     input logic [3:0] qb, input logic [15:0] amt);
    return {op, qa, qb, amt};
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic load(input int addr, input logic [25:0] w);
    load_en = 1'b1; load_addr = 4'(addr); load_word = w;
    step();
    load_en = 1'b0;
  endtask

  task automatic arrive(input int q, input int amt);
    arr_valid = 1'b1; arr_queue = 4'(q); arr_amt = 16'(amt);
    step();
    arr_valid = 1'b0;
  endtask

  task automatic level_of(input int q, output int lv);
    mon_queue = 4'(q);
    #0.1;
    lv = int'(mon_level);
  endtask

  task automatic measure(output int n);
    start = 1'b1;
    step();
    start = 1'b0;
    n = 0;
    while (!halted && n < 2000) begin
      if (busy) n++;
      step();
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    int n;
    int lv;
    rst_n = 1'b0; load_en = 1'b0; load_addr = '0; load_word = '0; start = 1'b0;
    arr_valid = 1'b0; arr_queue = '0; arr_amt = '0; snd_ready = 1'b0; mon_queue = '0;
    repeat (4) step();
    rst_n = 1'b1;
    repeat (4) step();

    // R1 reset state
    chk(busy, 0, "R1 busy");
    chk(halted, 0, "R1 halted");
    chk(stall, 0, "R1 stall");
    chk(snd_valid, 0, "R1 snd_valid");
    chk(pc, 0, "R1 pc");
    level_of(0, lv); chk(lv, 0, "R1 level q0");
    level_of(15, lv); chk(lv, 0, "R1 level q15");

    // R2 compute delays from the table
    for (int i = 0; i < NROW; i++) begin
      load(0, mk(2'b00, 4'd0, 4'd0, 16'(DLY_TAB[i][0])));
      measure(n);
      chk(n, DLY_TAB[i][1], "R2 compute busy cycles");
      chk(halted, 1, "R9 halted after compute");
    end

    // R6 arrival credit and saturation
    arrive(2, 5);
    level_of(2, lv); chk(lv, 5, "R6 credit q2");
    arrive(9, 16'hFFF0);
    arrive(9, 16'h0020);
    level_of(9, lv); chk(lv, 65535, "R6 saturate q9");

    // R3/R4 send blocked then accepted
    load(0, mk(2'b01, 4'd2, 4'd7, 16'd3));
    snd_ready = 1'b0;
    start = 1'b1; step(); start = 1'b0;
    chk(snd_valid, 1, "R3 snd_valid");
    chk(stall, 1, "R3 stall while not ready");
    chk(snd_src, 2, "R3 snd_src");
    chk(snd_dst, 7, "R3 snd_dst");
    chk(snd_amt, 3, "R3 snd_amt");
    step(); step();
    chk(pc, 0, "R3 pc held");
    level_of(2, lv); chk(lv, 5, "R4 no debit while waiting");
    snd_ready = 1'b1;
    step();
    snd_ready = 1'b0;
    level_of(2, lv); chk(lv, 2, "R4 debit on accept");
    chk(pc, 1, "R3 advance on accept");
    step();
    chk(halted, 1, "R9 halted after send");
    chk(busy, 0, "R9 busy low when halted");

    // R4 floor at zero
    load(0, mk(2'b01, 4'd2, 4'd7, 16'd10));
    snd_ready = 1'b1;
    start = 1'b1; step(); start = 1'b0;
    step();
    snd_ready = 1'b0;
    level_of(2, lv); chk(lv, 0, "R4 debit floors at zero");

    // R5 receive stalls until enough has arrived
    load(0, mk(2'b10, 4'd4, 4'd0, 16'd6));
    start = 1'b1; step(); start = 1'b0;
    chk(stall, 1, "R5 stall on empty queue");
    arrive(4, 4);
    level_of(4, lv); chk(lv, 4, "R5 partial arrival kept");
    chk(stall, 1, "R5 still stalled at 4 of 6");
    arrive(4, 2);
    chk(pc, 0, "R5 pc held until level seen");
    step();
    level_of(4, lv); chk(lv, 0, "R5 consumed on release");
    chk(pc, 1, "R5 advance on release");

    // R7 arrival and receive debit in the same cycle
    step(); step();
    arrive(5, 3);
    load(0, mk(2'b10, 4'd5, 4'd0, 16'd3));
    start = 1'b1; step(); start = 1'b0;
    arr_valid = 1'b1; arr_queue = 4'd5; arr_amt = 16'd10;
    step();
    arr_valid = 1'b0;
    level_of(5, lv); chk(lv, 10, "R7 net of arrival and debit");
    chk(pc, 1, "R7 receive advanced");
    step();

    // R8 loop: body of compute 2, jump back 3 times
    load(0, mk(2'b00, 4'd0, 4'd0, 16'd2));
    load(1, mk(2'b11, 4'd0, 4'd0, 16'd3));
    measure(n); chk(n, 13, "R8 loop count 3");
    measure(n); chk(n, 13, "R8 loop count reloaded on new run");
    load(0, mk(2'b00, 4'd0, 4'd0, 16'd1));
    load(1, mk(2'b11, 4'd0, 4'd0, 16'd0));
    measure(n); chk(n, 3, "R8 loop count 0 falls through");

    // R10 start ignored while busy
    load(0, mk(2'b00, 4'd0, 4'd0, 16'd1));
    load(1, mk(2'b00, 4'd0, 4'd0, 16'd8));
    start = 1'b1; step(); start = 1'b0;
    step();
    chk(pc, 1, "R10 pc before second start");
    start = 1'b1; step(); start = 1'b0;
    chk(pc, 1, "R10 pc kept after start while busy");
    chk(busy, 1, "R10 still busy");
    repeat (12) step();
    chk(halted, 1, "R9 halted after R10 program");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule